// File: doc/BRIEF.md
# Trigger Input Conditioning Channel

This block conditions a set of trigger input lines before they reach the trigger decision logic. Each line passes through four stages in a fixed order. It is first captured in a register, then delayed by a programmable number of steps. Next it is stretched to a programmable pulse length, and last it is thinned so that only one pulse in every 2^N reaches the channel output. Each line has its own enable bit. A line whose enable is low is removed at the capture stage, so it can neither produce an output pulse nor advance its thinning count.

The conditioned outputs are ORed into a start signal. A separate veto line is captured and stretched by a programmable amount. The anti-coincidence output is true while start is present and the stretched veto is absent. An 8-bit selector drives any stage of any channel, or one of the three combined signals, onto a single monitor pin. This lets the signal be observed at each point along the path.

Delay steps, width steps and veto steps are each a parameter number of clock ticks. The channel count is also a parameter. With the default settings one step is one clock tick.

Top module: `trigCond`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with all inputs low, `chanOut`, `startOr`, `vetoStretch`, `antiCoinc` and `tapOut` are all 0.
- R2: Channel `i` is captured as `chanIn[i] & chanEn[i]` on each clock edge, and the captured value is visible on monitor index `i` one cycle after the input is sampled. An input pulse on a disabled channel produces no `chanOut` pulse and does not advance that channel's thinning count.
- R3: Monitor index `NUM_CH+i` shows the captured signal of channel `i` delayed by `d*DLY_TICKS` cycles, where `d = delayCfg[i*DLY_W +: DLY_W]`. With `d = 0` it equals the captured signal.
- R4: Each rising edge of the delayed signal starts a stretched pulse one cycle later. The pulse lasts exactly `WID_BASE + w*WID_TICKS` cycles, where `w = widthCfg[i*WID_W +: WID_W]`, whatever the length of the input pulse. For a single pulse that passes, `chanOut[i]` first goes high `2 + d*DLY_TICKS` cycles after the input is sampled.
- R5: Each channel counts rising edges of its delayed signal from 0 after reset. With `n = scaleCfg[i*SCALE_W +: SCALE_W]`, the k-th edge (k counted from 1) reaches `chanOut[i]` only when k is a multiple of 2^n. With `n = 0` every pulse passes.
- R6: `vetoStretch` is high in the cycle after `vetoIn` is sampled high. For a single-cycle `vetoIn` pulse it stays high for `1 + v*VETO_TICKS` cycles, where `v = vetoWidthCfg`.
- R7: `startOr` is the OR of all `chanOut` bits. `antiCoinc` is high exactly when `startOr` is high and `vetoStretch` is low.
- R8: Monitor map for `tapSel`:
  - `2*NUM_CH+i` is the stretched signal of channel `i` before thinning.
  - `3*NUM_CH+i` is `chanOut[i]`.
  - 127 is `startOr`, 128 is `vetoStretch` and 129 is `antiCoinc`.
  - Every other index gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanIn | input | NUM_CH | Raw trigger inputs |
| chanEn | input | NUM_CH | Per-channel enable |
| delayCfg | input | NUM_CH*DLY_W | Delay step count per channel |
| widthCfg | input | NUM_CH*WID_W | Width step count per channel |
| scaleCfg | input | NUM_CH*SCALE_W | Thinning exponent per channel |
| vetoIn | input | 1 | Raw veto input |
| vetoWidthCfg | input | VETO_W | Veto stretch step count |
| tapSel | input | 8 | Monitor selector |
| chanOut | output | NUM_CH | Conditioned, thinned channel pulses |
| startOr | output | 1 | OR of all channel outputs |
| vetoStretch | output | 1 | Stretched veto |
| antiCoinc | output | 1 | Start present and veto absent |
| tapOut | output | 1 | Selected monitor signal |

## Verification
The bench sweeps every delay value on every channel, pairing each one with a different width setting. It checks both the first high cycle and the pulse length. A delay tap that is off by one, or a stretch counter that counts one cycle too many or too few, therefore shows up at once. The thinning exponent is swept after a fresh reset with trains of pulses, so a counter that passes on the first edge instead of the 2^n-th, or that fails to wrap, changes which pulses appear. Pulses sent on a disabled channel are followed by enabled pulses with a thinning factor of two. A design that counted the disabled edges would pass the wrong pulse. The veto is swept over every stretch value and overlapped with a known start window to fix the anti-coincidence count, and unused monitor indices are checked to stay quiet.

// File: rtl/trigCond_pkg.sv
package trigCond_pkg;
  // Per-channel strobes from the edge/thinning control to the datapath
  typedef struct packed {
    logic loadWidth;   // a rising edge of the delayed signal was seen
    logic passPulse;   // this edge is the one that survives thinning
  } chStrobe_t;
endpackage

// File: rtl/trigCondCtrl.sv
module trigCondCtrl
  import trigCond_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int SCALE_W = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH-1:0]           delayed,
  input  logic [NUM_CH*SCALE_W-1:0]   scaleCfg,
  input  logic                        vetoSync,
  output chStrobe_t [NUM_CH-1:0]      strobes,
  output logic                        vetoLoad
);
  localparam int CNT_W = (1 << SCALE_W) - 1;

  logic [NUM_CH-1:0] delayedPrev;
  logic              vetoPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayedPrev <= '0;
      vetoPrev    <= 1'b0;
    end else begin
      delayedPrev <= delayed;
      vetoPrev    <= vetoSync;
    end
  end

  assign vetoLoad = vetoSync & ~vetoPrev;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_scale
    logic [CNT_W-1:0]   edgeCnt;
    logic [CNT_W-1:0]   nextCnt;
    logic [CNT_W-1:0]   mask;
    logic [SCALE_W-1:0] nSel;
    logic               rise;

    assign nSel    = scaleCfg[ch*SCALE_W +: SCALE_W];
    assign mask    = ~({CNT_W{1'b1}} << nSel);
    assign rise    = delayed[ch] & ~delayedPrev[ch];
    assign nextCnt = (edgeCnt + 1'b1) & mask;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     edgeCnt <= '0;
      else if (rise) edgeCnt <= nextCnt;
    end

    assign strobes[ch].loadWidth = rise;
    assign strobes[ch].passPulse = rise && (nextCnt == '0);
  end
endmodule

// File: rtl/trigCondPath.sv
module trigCondPath
  import trigCond_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DLY_W      = 4,
  parameter int DLY_TICKS  = 1,
  parameter int WID_W      = 4,
  parameter int WID_BASE   = 1,
  parameter int WID_TICKS  = 1,
  parameter int VETO_W     = 4,
  parameter int VETO_TICKS = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH-1:0]          chanIn,
  input  logic [NUM_CH-1:0]          chanEn,
  input  logic [NUM_CH*DLY_W-1:0]    delayCfg,
  input  logic [NUM_CH*WID_W-1:0]    widthCfg,
  input  logic                       vetoIn,
  input  logic [VETO_W-1:0]          vetoWidthCfg,
  input  chStrobe_t [NUM_CH-1:0]     strobes,
  input  logic                       vetoLoad,
  output logic [NUM_CH-1:0]          synced,
  output logic [NUM_CH-1:0]          delayed,
  output logic [NUM_CH-1:0]          stretched,
  output logic [NUM_CH-1:0]          chanOut,
  output logic                       vetoSync,
  output logic                       vetoStretch
);
  localparam int DLY_MAX  = ((1 << DLY_W) - 1) * DLY_TICKS;
  localparam int TAP_W    = $clog2(DLY_MAX + 1);
  localparam int LINE_LEN = 1 << TAP_W;
  localparam int WID_MAX  = WID_BASE + ((1 << WID_W) - 1) * WID_TICKS;
  localparam int WCNT_W   = $clog2(WID_MAX + 1);
  localparam int VETO_MAX = ((1 << VETO_W) - 1) * VETO_TICKS;
  localparam int VCNT_W   = (VETO_MAX < 1) ? 1 : $clog2(VETO_MAX + 1);

  // Stage 1: capture with enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) synced <= '0;
    else       synced <= chanIn & chanEn;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [LINE_LEN-1:0] line;
    logic [TAP_W-1:0]    tapPos;
    logic [WCNT_W-1:0]   wCnt;
    logic                passFlag;

    // Stage 2: delay line with a selectable tap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) line <= '0;
      else       line <= {line[LINE_LEN-2:0], synced[ch]};
    end

    assign tapPos      = TAP_W'(32'(delayCfg[ch*DLY_W +: DLY_W]) * DLY_TICKS);
    assign delayed[ch] = (tapPos == '0) ? synced[ch] : line[tapPos - 1'b1];

    // Stage 3: fixed-length stretch restarted on every rising edge
    // Stage 4: the thinning decision is held for the whole stretched pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wCnt     <= '0;
        passFlag <= 1'b0;
      end else if (strobes[ch].loadWidth) begin
        wCnt     <= WCNT_W'(WID_BASE + 32'(widthCfg[ch*WID_W +: WID_W]) * WID_TICKS);
        passFlag <= strobes[ch].passPulse;
      end else if (wCnt != '0) begin
        wCnt     <= wCnt - 1'b1;
      end
    end

    assign stretched[ch] = (wCnt != '0);
    assign chanOut[ch]   = stretched[ch] & passFlag;
  end

  // Veto capture and stretch
  logic [VCNT_W-1:0] vCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vetoSync <= 1'b0;
      vCnt     <= '0;
    end else begin
      vetoSync <= vetoIn;
      if (vetoLoad)        vCnt <= VCNT_W'(32'(vetoWidthCfg) * VETO_TICKS);
      else if (vCnt != '0) vCnt <= vCnt - 1'b1;
    end
  end

  assign vetoStretch = vetoSync | (vCnt != '0);
endmodule

// File: rtl/trigCondTap.sv
module trigCondTap #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] synced,
  input  logic [NUM_CH-1:0] delayed,
  input  logic [NUM_CH-1:0] stretched,
  input  logic [NUM_CH-1:0] chanOut,
  input  logic              startOr,
  input  logic              vetoStretch,
  input  logic              antiCoinc,
  input  logic [7:0]        tapSel,
  output logic              tapOut
);
  // The four per-channel groups must fit below index 127
  logic [255:0] taps;

  always_comb begin
    taps                      = '0;
    taps[0 +: NUM_CH]         = synced;
    taps[NUM_CH +: NUM_CH]    = delayed;
    taps[2*NUM_CH +: NUM_CH]  = stretched;
    taps[3*NUM_CH +: NUM_CH]  = chanOut;
    taps[127]                 = startOr;
    taps[128]                 = vetoStretch;
    taps[129]                 = antiCoinc;
  end

  assign tapOut = taps[tapSel];
endmodule

// File: rtl/trigCond.sv
module trigCond
  import trigCond_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DLY_W      = 4,
  parameter int DLY_TICKS  = 1,
  parameter int WID_W      = 4,
  parameter int WID_BASE   = 1,
  parameter int WID_TICKS  = 1,
  parameter int SCALE_W    = 3,
  parameter int VETO_W     = 4,
  parameter int VETO_TICKS = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         chanIn,
  input  logic [NUM_CH-1:0]         chanEn,
  input  logic [NUM_CH*DLY_W-1:0]   delayCfg,
  input  logic [NUM_CH*WID_W-1:0]   widthCfg,
  input  logic [NUM_CH*SCALE_W-1:0] scaleCfg,
  input  logic                      vetoIn,
  input  logic [VETO_W-1:0]         vetoWidthCfg,
  input  logic [7:0]                tapSel,
  output logic [NUM_CH-1:0]         chanOut,
  output logic                      startOr,
  output logic                      vetoStretch,
  output logic                      antiCoinc,
  output logic                      tapOut
);
  chStrobe_t [NUM_CH-1:0] strobes;
  logic                   vetoLoad;
  logic                   vetoSync;
  logic [NUM_CH-1:0]      synced;
  logic [NUM_CH-1:0]      delayed;
  logic [NUM_CH-1:0]      stretched;

  trigCondCtrl #(
    .NUM_CH (NUM_CH),
    .SCALE_W(SCALE_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .delayed (delayed),
    .scaleCfg(scaleCfg),
    .vetoSync(vetoSync),
    .strobes (strobes),
    .vetoLoad(vetoLoad)
  );

  trigCondPath #(
    .NUM_CH    (NUM_CH),
    .DLY_W     (DLY_W),
    .DLY_TICKS (DLY_TICKS),
    .WID_W     (WID_W),
    .WID_BASE  (WID_BASE),
    .WID_TICKS (WID_TICKS),
    .VETO_W    (VETO_W),
    .VETO_TICKS(VETO_TICKS)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .chanIn      (chanIn),
    .chanEn      (chanEn),
    .delayCfg    (delayCfg),
    .widthCfg    (widthCfg),
    .vetoIn      (vetoIn),
    .vetoWidthCfg(vetoWidthCfg),
    .strobes     (strobes),
    .vetoLoad    (vetoLoad),
    .synced      (synced),
    .delayed     (delayed),
    .stretched   (stretched),
    .chanOut     (chanOut),
    .vetoSync    (vetoSync),
    .vetoStretch (vetoStretch)
  );

  assign startOr   = |chanOut;
  assign antiCoinc = startOr & ~vetoStretch;

  trigCondTap #(
    .NUM_CH(NUM_CH)
  ) u_tap (
    .synced     (synced),
    .delayed    (delayed),
    .stretched  (stretched),
    .chanOut    (chanOut),
    .startOr    (startOr),
    .vetoStretch(vetoStretch),
    .antiCoinc  (antiCoinc),
    .tapSel     (tapSel),
    .tapOut     (tapOut)
  );
endmodule

// File: rtl/trigCond_chk.sv
module trigCond_chk #(
  parameter int NUM_CH    = 4,
  parameter int DLY_W     = 4,
  parameter int DLY_TICKS = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chanIn,
  input logic [NUM_CH-1:0] chanEn,
  input logic              vetoIn,
  input logic [7:0]        tapSel,
  input logic [NUM_CH-1:0] chanOut,
  input logic              vetoStretch,
  input logic              antiCoinc,
  input logic              tapOut
);
  localparam int MAX_LAT = ((1 << DLY_W) - 1) * DLY_TICKS + 2;
  localparam int SAT     = MAX_LAT + 1;
  localparam int SCNT_W  = $clog2(SAT + 1);

  // A registered veto is stretched from the next cycle on
  assert_veto_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    vetoIn |=> vetoStretch);

  // Any sampled veto blocks the anti-coincidence in the next cycle
  assert_veto_blocks_anti_R7: assert property (@(posedge clk) disable iff (!rstN)
    vetoIn |=> !antiCoinc);

  // Indices above the last named one are silent
  assert_unused_tap_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tapSel > 8'd129) |-> !tapOut);

  // An output pulse needs an enabled input within the maximum latency
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lat
    logic [SCNT_W-1:0] sinceIn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          sinceIn <= SCNT_W'(SAT);
      else if (chanIn[ch] && chanEn[ch])  sinceIn <= '0;
      else if (sinceIn != SCNT_W'(SAT))   sinceIn <= sinceIn + 1'b1;
    end

    assert_out_needs_input_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chanOut[ch]) |-> (sinceIn <= SCNT_W'(MAX_LAT)));
  end
endmodule

bind trigCond trigCond_chk #(
  .NUM_CH   (NUM_CH),
  .DLY_W    (DLY_W),
  .DLY_TICKS(DLY_TICKS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chanIn     (chanIn),
  .chanEn     (chanEn),
  .vetoIn     (vetoIn),
  .tapSel     (tapSel),
  .chanOut    (chanOut),
  .vetoStretch(vetoStretch),
  .antiCoinc  (antiCoinc),
  .tapOut     (tapOut)
);

// File: tb/trigCond_tb.sv
`timescale 1ns/1ps
module trigCond_tb;
  localparam int NC  = 4;
  localparam int DW  = 4;
  localparam int DT  = 1;
  localparam int WW  = 4;
  localparam int WB  = 1;
  localparam int WT  = 1;
  localparam int SW  = 3;
  localparam int VW  = 4;
  localparam int VT  = 1;
  localparam int SPAN = 48;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NC-1:0]     chanIn = '0;
  logic [NC-1:0]     chanEn = '1;
  logic [NC*DW-1:0]  delayCfg = '0;
  logic [NC*WW-1:0]  widthCfg = '0;
  logic [NC*SW-1:0]  scaleCfg = '0;
  logic              vetoIn = 1'b0;
  logic [VW-1:0]     vetoWidthCfg = '0;
  logic [7:0]        tapSel = '0;
  logic [NC-1:0]     chanOut;
  logic              startOr, vetoStretch, antiCoinc, tapOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  trigCond #(
    .NUM_CH(NC), .DLY_W(DW), .DLY_TICKS(DT), .WID_W(WW), .WID_BASE(WB),
    .WID_TICKS(WT), .SCALE_W(SW), .VETO_W(VW), .VETO_TICKS(VT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .chanEn(chanEn),
    .delayCfg(delayCfg), .widthCfg(widthCfg), .scaleCfg(scaleCfg),
    .vetoIn(vetoIn), .vetoWidthCfg(vetoWidthCfg), .tapSel(tapSel),
    .chanOut(chanOut), .startOr(startOr), .vetoStretch(vetoStretch),
    .antiCoinc(antiCoinc), .tapOut(tapOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // which: 0 tapOut, 1 antiCoinc, 2 vetoStretch
  task automatic run(input int ch, input bit fireCh, input bit fireVeto, input int hold,
                     input int which, output int firstHi, output int nHi, output int nOut);
    @(negedge clk);
    if (fireCh)   chanIn[ch] = 1'b1;
    if (fireVeto) vetoIn = 1'b1;
    firstHi = -1; nHi = 0; nOut = 0;
    for (int k = 1; k <= SPAN; k++) begin
      logic s;
      @(negedge clk);
      if (k == hold) begin chanIn = '0; vetoIn = 1'b0; end
      s = (which == 0) ? tapOut : (which == 1) ? antiCoinc : vetoStretch;
      if (s) begin nHi++; if (firstHi < 0) firstHi = k; end
      if (chanOut[ch]) nOut++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int f, n, o;
    // R1: quiet during and after reset
    repeat (2) @(negedge clk);
    check("R1", "chanOut in reset", int'(chanOut), 0);
    check("R1", "startOr/veto/anti in reset", int'({startOr, vetoStretch, antiCoinc, tapOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", int'({chanOut, startOr, vetoStretch, antiCoinc, tapOut}), 0);

    // R2: capture tap, one cycle latency
    for (int ch = 0; ch < NC; ch++) begin
      tapSel = 8'(ch);
      run(ch, 1, 0, 1, 0, f, n, o);
      check("R2", "capture tap first", f, 1);
      check("R2", "capture tap length", n, 1);
    end

    // R3 and R4: delay sweep with varying widths
    for (int ch = 0; ch < NC; ch++) begin
      for (int d = 0; d < (1 << DW); d++) begin
        int w;
        w = (d * 7 + ch * 3) % (1 << WW);
        delayCfg[ch*DW +: DW] = DW'(d);
        widthCfg[ch*WW +: WW] = WW'(w);
        tapSel = 8'(NC + ch);
        run(ch, 1, 0, 1, 0, f, n, o);
        check("R3", "delayed tap first", f, 1 + d * DT);
        check("R3", "delayed tap length", n, 1);
        tapSel = 8'(3 * NC + ch);
        run(ch, 1, 0, 1, 0, f, n, o);
        check("R4", "chanOut first", f, 2 + d * DT);
        check("R4", "chanOut length", n, WB + w * WT);
        check("R8", "out tap equals chanOut", o, WB + w * WT);
      end
    end

    // R4: long input, short width
    delayCfg = '0; widthCfg = '0;
    tapSel = 8'(3 * NC);
    run(0, 1, 0, 4, 0, f, n, o);
    check("R4", "held input stretched length", n, WB);

    // R5: thinning sweep
    widthCfg[0 +: WW] = WW'(2);
    tapSel = 8'(3 * NC);
    for (int sc = 0; sc < 4; sc++) begin
      doReset();
      scaleCfg[0 +: SW] = SW'(sc);
      for (int k = 1; k <= 2 * (1 << sc) + 1; k++) begin
        int expN;
        expN = ((k % (1 << sc)) == 0) ? (WB + 2 * WT) : 0;
        run(0, 1, 0, 1, 0, f, n, o);
        check("R5", $sformatf("thinning n=%0d pulse %0d", sc, k), n, expN);
      end
    end

    // R8: stretched tap shows a pulse that thinning removes
    doReset();
    scaleCfg[0 +: SW] = SW'(1);
    tapSel = 8'(2 * NC);
    run(0, 1, 0, 1, 0, f, n, o);
    check("R8", "stretched tap before thinning", n, WB + 2 * WT);
    check("R8", "thinned chanOut", o, 0);

    // R2: disabled input neither pulses nor counts
    doReset();
    tapSel = 8'(0);
    chanEn[0] = 1'b0;
    run(0, 1, 0, 1, 0, f, n, o);
    check("R2", "disabled capture tap", n, 0);
    check("R2", "disabled chanOut", o, 0);
    chanEn[0] = 1'b1;
    run(0, 1, 0, 1, 0, f, n, o);
    check("R2", "first enabled pulse thinned", o, 0);
    run(0, 1, 0, 1, 0, f, n, o);
    check("R2", "second enabled pulse passes", o, WB + 2 * WT);
    scaleCfg = '0;

    // R6: veto stretch sweep
    for (int v = 0; v < (1 << VW); v++) begin
      vetoWidthCfg = VW'(v);
      run(0, 0, 1, 1, 2, f, n, o);
      check("R6", "veto first", f, 1);
      check("R6", "veto length", n, 1 + v * VT);
    end

    // R7: anti-coincidence with start window [2,7]
    widthCfg[0 +: WW] = WW'(5);
    for (int v = 0; v < 8; v++) begin
      int expA;
      vetoWidthCfg = VW'(v);
      expA = 0;
      for (int k = 2; k <= 1 + WB + 5 * WT; k++)
        if (k > 1 + v * VT) expA++;
      run(0, 1, 1, 1, 1, f, n, o);
      check("R7", $sformatf("anti count v=%0d", v), n, expA);
    end
    tapSel = 8'd127;
    run(0, 1, 0, 1, 0, f, n, o);
    check("R7", "startOr length", n, WB + 5 * WT);
    tapSel = 8'd128;
    vetoWidthCfg = VW'(3);
    run(0, 0, 1, 1, 0, f, n, o);
    check("R8", "veto tap length", n, 1 + 3 * VT);
    tapSel = 8'd129;
    run(1, 1, 0, 1, 0, f, n, o);
    check("R8", "anti tap without veto", n, WB + int'(widthCfg[WW +: WW]) * WT);
    run(0, 0, 1, 1, 1, f, n, o);
    check("R7", "veto alone gives no anti", n, 0);

    // R8: unused indices stay low
    tapSel = 8'd100;
    run(0, 1, 1, 1, 0, f, n, o);
    check("R8", "unused tap 100", n, 0);
    tapSel = 8'd200;
    run(0, 1, 1, 1, 0, f, n, o);
    check("R8", "unused tap 200", n, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule